// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointers and Level Flags

This block moves data words from a producer running on one clock to a consumer running on an unrelated clock. Words are kept in a small register array whose depth is a power of two. Each side has its own binary pointer, one bit wider than the address. The pointer is re-encoded in Gray code in a register, and that registered copy is carried to the opposite side through a chain of synchronizer flops. Because one bit changes per step, a sample taken mid-transition still yields either the old pointer or the new one.

The write side works out `full` and a programmable `almost_full` from its own pointer and the synchronized read pointer. The read side works out `empty` and a programmable `almost_empty` the same way. The synchronized pointer can only lag the true one, so a flag may stay set for a few cycles longer than needed but never clears too early. A write while full or a read while empty changes nothing in the FIFO and latches an error bit in that side's domain. Each side's reset input is applied asynchronously and released on its own clock through an internal synchronizer.

Top module: `xdom_fifo`

## Requirements
- R1: The pointer copy that crosses to the other domain is a registered Gray code, and successive values of it differ in at most one bit.
- R2: `empty` is 1 exactly when the read pointer equals the synchronized write pointer including the wrap bit. After a write into an empty FIFO, `empty` stays 1 for at least one further read-clock edge, because the new pointer must first pass the synchronizer.
- R3: With no reads, `full` rises on the write-clock edge that accepts the DEPTH-th word. The occupancy seen on the write side never exceeds DEPTH.
- R4: A write attempted while `full` is 1 stores nothing and leaves the write pointer unchanged. It sets `wr_err` on the next write-clock edge.
- R5: A read attempted while `empty` is 1 leaves `rd_data` and the read pointer unchanged. It sets `rd_err` on the next read-clock edge.
- R6: Words leave in the order they were written. `rd_data` shows the word on the read-clock edge that accepts the read (`rd_en` high while `empty` is 0).
- R7: `almost_full` is 1 when the write-side occupancy (write pointer minus synchronized read pointer) is at least AFULL_LVL.
- R8: `almost_empty` is 1 when the read-side occupancy (synchronized write pointer minus read pointer) is at most AEMPTY_LVL.
- R9: While a reset input is low, and after it is released, that side's outputs start at their reset values until the first operation: `empty`=1, `almost_empty`=1, `rd_err`=0, `rd_data`=0; `full`=0, `almost_full`=0, `wr_err`=0.
- R10: `wr_err` and `rd_err` stay set until their own domain is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, active low, asynchronous assert |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free entry seen on the write side |
| almost_full | output | 1 | Write-side occupancy at or above AFULL_LVL |
| wr_err | output | 1 | Sticky flag: a write was attempted while full |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, active low, asynchronous assert |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Last word read |
| empty | output | 1 | No word seen on the read side |
| almost_empty | output | 1 | Read-side occupancy at or below AEMPTY_LVL |
| rd_err | output | 1 | Sticky flag: a read was attempted while empty |

## Verification
The bound checker watches four things on every edge of the relevant clock: the one-bit step of each crossing Gray pointer, the frozen pointer and the error bit after a refused write or read, the write-side occupancy bound, and the stickiness of both error flags. Some behaviours only show in the bench's scenarios against its scoreboard. These are data ordering across two unrelated clocks, the exact write that raises `full` and `almost_full`, the read-by-read fall of `almost_empty`, and the lag of `empty` behind a first write.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/xdom_rst_sync.sv
module xdom_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic srst_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/xdom_ptr_sync.sv
module xdom_ptr_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg_q[s] <= '0;
            else if (s == 0) stg_q[s] <= d;
            else             stg_q[s] <= stg_q[(s > 0) ? s-1 : 0];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/xdom_wr_ctl.sv
module xdom_wr_ctl
    import xdom_fifo_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int AFULL_LVL = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic [ADDR_W:0]   wbin,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic              wacc,
    output logic              full,
    output logic              afull,
    output logic              err
);
    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          afull;
        logic          err;
    } wst_t;

    wst_t st_d, st_q;
    logic [PW-1:0] nxt_bin, rd_bin, occ;

    always_comb begin
        st_d    = st_q;
        wacc    = wr_en & ~st_q.full;
        nxt_bin = st_q.bin + PW'(wacc);
        rd_bin  = PW'(gray2bin(32'(rgray_sync)));
        occ     = nxt_bin - rd_bin;
        st_d.bin   = nxt_bin;
        st_d.gray  = PW'(bin2gray(32'(nxt_bin)));
        st_d.full  = (nxt_bin[ADDR_W] != rd_bin[ADDR_W]) &&
                     (nxt_bin[ADDR_W-1:0] == rd_bin[ADDR_W-1:0]);
        st_d.afull = ({1'b0, occ} >= (PW+1)'(AFULL_LVL));
        st_d.err   = st_q.err | (wr_en & st_q.full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wbin  = st_q.bin;
    assign wgray = st_q.gray;
    assign waddr = st_q.bin[ADDR_W-1:0];
    assign full  = st_q.full;
    assign afull = st_q.afull;
    assign err   = st_q.err;
endmodule

// File: rtl/xdom_rd_ctl.sv
module xdom_rd_ctl
    import xdom_fifo_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int AEMPTY_LVL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_sync,
    output logic [ADDR_W:0]   rbin,
    output logic [ADDR_W:0]   rgray,
    output logic [ADDR_W-1:0] raddr,
    output logic              racc,
    output logic              empty,
    output logic              aempty,
    output logic              err
);
    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty;
        logic          aempty;
        logic          err;
    } rst_t;

    localparam rst_t RST_VAL = '{bin: '0, gray: '0, empty: 1'b1, aempty: 1'b1, err: 1'b0};

    rst_t st_d, st_q;
    logic [PW-1:0] nxt_bin, wr_bin, occ;

    always_comb begin
        st_d    = st_q;
        racc    = rd_en & ~st_q.empty;
        nxt_bin = st_q.bin + PW'(racc);
        wr_bin  = PW'(gray2bin(32'(wgray_sync)));
        occ     = wr_bin - nxt_bin;
        st_d.bin    = nxt_bin;
        st_d.gray   = PW'(bin2gray(32'(nxt_bin)));
        st_d.empty  = (nxt_bin == wr_bin);
        st_d.aempty = ({1'b0, occ} <= (PW+1)'(AEMPTY_LVL));
        st_d.err    = st_q.err | (rd_en & st_q.empty);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign rbin   = st_q.bin;
    assign rgray  = st_q.gray;
    assign raddr  = st_q.bin[ADDR_W-1:0];
    assign empty  = st_q.empty;
    assign aempty = st_q.aempty;
    assign err    = st_q.err;
endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo #(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 3,
    parameter int SYNC_N     = 2,
    parameter int AFULL_LVL  = 6,
    parameter int AEMPTY_LVL = 2
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              almost_full,
    output logic              wr_err,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              almost_empty,
    output logic              rd_err
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    logic              wrst_s_n, rrst_s_n;
    logic [PW-1:0]     wbin, wgray, rbin, rgray, wgray_at_r, rgray_at_w;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              wacc, racc;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdat_q;

    xdom_rst_sync #(.STAGES(SYNC_N)) u_wrst (.clk(wclk), .arst_n(wrst_n), .srst_n(wrst_s_n));
    xdom_rst_sync #(.STAGES(SYNC_N)) u_rrst (.clk(rclk), .arst_n(rrst_n), .srst_n(rrst_s_n));

    xdom_ptr_sync #(.W(PW), .STAGES(SYNC_N)) u_w2r (
        .clk(rclk), .rst_n(rrst_s_n), .d(wgray), .q(wgray_at_r));
    xdom_ptr_sync #(.W(PW), .STAGES(SYNC_N)) u_r2w (
        .clk(wclk), .rst_n(wrst_s_n), .d(rgray), .q(rgray_at_w));

    xdom_wr_ctl #(.ADDR_W(ADDR_W), .AFULL_LVL(AFULL_LVL)) u_wr (
        .clk(wclk), .rst_n(wrst_s_n), .wr_en(wr_en), .rgray_sync(rgray_at_w),
        .wbin(wbin), .wgray(wgray), .waddr(waddr), .wacc(wacc),
        .full(full), .afull(almost_full), .err(wr_err));

    xdom_rd_ctl #(.ADDR_W(ADDR_W), .AEMPTY_LVL(AEMPTY_LVL)) u_rd (
        .clk(rclk), .rst_n(rrst_s_n), .rd_en(rd_en), .wgray_sync(wgray_at_r),
        .rbin(rbin), .rgray(rgray), .raddr(raddr), .racc(racc),
        .empty(empty), .aempty(almost_empty), .err(rd_err));

    always_ff @(posedge wclk) begin
        if (wacc) mem[waddr] <= wr_data;
    end

    always_ff @(posedge rclk or negedge rrst_s_n) begin
        if (!rrst_s_n)  rdat_q <= '0;
        else if (racc)  rdat_q <= mem[raddr];
    end

    assign rd_data = rdat_q;
endmodule

// File: rtl/xdom_fifo_chk.sv
module xdom_fifo_chk
    import xdom_fifo_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic            wclk,
    input logic            rclk,
    input logic            wrst_s_n,
    input logic            rrst_s_n,
    input logic            wr_en,
    input logic            rd_en,
    input logic            full,
    input logic            empty,
    input logic            wr_err,
    input logic            rd_err,
    input logic [ADDR_W:0] wbin,
    input logic [ADDR_W:0] rbin,
    input logic [ADDR_W:0] wgray,
    input logic [ADDR_W:0] rgray,
    input logic [ADDR_W:0] rgray_at_w
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PW-1:0] occ_w;
    assign occ_w = wbin - PW'(gray2bin(32'(rgray_at_w)));

    p_wgray_step_r1: assert property (@(posedge wclk) disable iff (!wrst_s_n)
        $countones(wgray ^ $past(wgray)) <= 1);
    p_rgray_step_r1: assert property (@(posedge rclk) disable iff (!rrst_s_n)
        $countones(rgray ^ $past(rgray)) <= 1);
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!wrst_s_n)
        {1'b0, occ_w} <= (PW+1)'(DEPTH));
    p_full_freeze_r4: assert property (@(posedge wclk) disable iff (!wrst_s_n)
        (wr_en && full) |=> ($stable(wbin) && wr_err));
    p_empty_freeze_r5: assert property (@(posedge rclk) disable iff (!rrst_s_n)
        (rd_en && empty) |=> ($stable(rbin) && rd_err));
    p_wr_err_hold_r10: assert property (@(posedge wclk) disable iff (!wrst_s_n)
        wr_err |=> wr_err);
    p_rd_err_hold_r10: assert property (@(posedge rclk) disable iff (!rrst_s_n)
        rd_err |=> rd_err);
endmodule

bind xdom_fifo xdom_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .wrst_s_n(wrst_s_n), .rrst_s_n(rrst_s_n),
    .wr_en(wr_en), .rd_en(rd_en), .full(full), .empty(empty),
    .wr_err(wr_err), .rd_err(rd_err), .wbin(wbin), .rbin(rbin),
    .wgray(wgray), .rgray(rgray), .rgray_at_w(rgray_at_w));

// File: tb/xdom_fifo_tb.sv
module xdom_fifo_tb;
    localparam int DW = 16, AW = 3, DEPTH = 8, AFL = 6, AEL = 2;

    logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
    logic wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic full, almost_full, wr_err, empty, almost_empty, rd_err;

    int total = 0, bad = 0;
    logic [DW-1:0] sb[$];

    always #2ns wclk = ~wclk;
    always #3.5ns rclk = ~rclk;

    xdom_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_N(2), .AFULL_LVL(AFL), .AEMPTY_LVL(AEL)) u_dut (
        .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .almost_full(almost_full), .wr_err(wr_err),
        .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .almost_empty(almost_empty), .rd_err(rd_err));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // driver: waits for space, then pushes the expected word
    task automatic push_word(input logic [DW-1:0] v);
        @(negedge wclk);
        while (full) @(negedge wclk);
        wr_en = 1; wr_data = v; sb.push_back(v);
        @(negedge wclk);
        wr_en = 0;
    endtask

    // monitor: takes one word and compares it with the scoreboard head
    task automatic pop_word(input string req);
        logic [DW-1:0] e;
        @(negedge rclk);
        while (empty) @(negedge rclk);
        rd_en = 1;
        @(negedge rclk);
        rd_en = 0;
        e = sb.pop_front();
        chk(rd_data == e, req, int'(rd_data), int'(e));
    endtask

    task automatic settle();
        repeat (12) @(negedge rclk);
        repeat (12) @(negedge wclk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge wclk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [DW-1:0] held;
        repeat (4) @(negedge wclk);
        // R9: outputs at reset values while held and after release
        chk(empty == 1 && almost_empty == 1, "R9 rd flags in reset", {30'd0, empty, almost_empty}, 3);
        wrst_n = 1; rrst_n = 1;
        settle();
        chk(empty == 1, "R9 empty", empty, 1);
        chk(almost_empty == 1, "R9 almost_empty", almost_empty, 1);
        chk(full == 0 && almost_full == 0, "R9 full flags", {30'd0, full, almost_full}, 0);
        chk(wr_err == 0 && rd_err == 0, "R9 err flags", {30'd0, wr_err, rd_err}, 0);
        chk(rd_data == 0, "R9 rd_data", int'(rd_data), 0);

        // R2: first write is not visible one read edge later
        @(negedge wclk);
        wr_en = 1; wr_data = 16'hA5A5; sb.push_back(16'hA5A5);
        @(posedge wclk); #0.1ns wr_en = 0;
        @(posedge rclk); @(negedge rclk);
        chk(empty == 1, "R2 empty lags write", empty, 1);
        repeat (10) @(negedge rclk);
        chk(empty == 0, "R2 empty clears", empty, 0);
        pop_word("R6 single word");
        chk(empty == 1, "R2 empty after drain", empty, 1);

        // R5: read while empty is ignored
        held = rd_data;
        @(negedge rclk); rd_en = 1;
        @(negedge rclk); rd_en = 0;
        chk(rd_data == held, "R5 rd_data kept", int'(rd_data), int'(held));
        chk(rd_err == 1, "R5 rd_err set", rd_err, 1);
        chk(empty == 1, "R5 still empty", empty, 1);
        settle();

        // R3 R4 R7: fill without reads, one extra write
        for (int i = 0; i < DEPTH + 1; i++) begin
            bit was_full;
            @(negedge wclk);
            was_full = full;
            wr_en = 1; wr_data = 16'h1000 + 16'(i);
            if (!was_full) sb.push_back(wr_data);
            @(negedge wclk);
            wr_en = 0;
            if (i < DEPTH) begin
                chk(almost_full == ((i + 1) >= AFL), "R7 almost_full level", almost_full, int'((i + 1) >= AFL));
                chk(full == (i + 1 == DEPTH), "R3 full at depth", full, int'(i + 1 == DEPTH));
            end else begin
                chk(wr_err == 1, "R4 wr_err set", wr_err, 1);
                chk(full == 1, "R4 still full", full, 1);
            end
        end
        settle();

        // R6 R8: drain, almost_empty tracks read-side occupancy
        for (int k = 1; k <= DEPTH; k++) begin
            pop_word("R6 drain order");
            chk(almost_empty == ((DEPTH - k) <= AEL), "R8 almost_empty level", almost_empty, int'((DEPTH - k) <= AEL));
        end
        chk(sb.size() == 0, "R4 ignored write not stored", sb.size(), 0);
        chk(empty == 1, "R2 empty after full drain", empty, 1);
        settle();
        chk(full == 0 && almost_full == 0, "R3 full clears after drain", {30'd0, full, almost_full}, 0);

        // R6: concurrent streaming across both clocks
        fork
            for (int i = 0; i < 40; i++) begin
                push_word(16'(16'h3C00 ^ (i * 16'h0137)));
                if (i % 5 == 0) repeat (3) @(negedge wclk);
            end
            for (int i = 0; i < 40; i++) begin
                pop_word("R6 stream order");
                if (i % 7 == 0) repeat (4) @(negedge rclk);
            end
        join
        settle();

        // R10: errors remain until reset, then clear
        chk(wr_err == 1 && rd_err == 1, "R10 errors sticky", {30'd0, wr_err, rd_err}, 3);
        wrst_n = 0; rrst_n = 0;
        repeat (3) @(negedge wclk);
        wrst_n = 1; rrst_n = 1;
        settle();
        chk(wr_err == 0 && rd_err == 0, "R10 errors cleared by reset", {30'd0, wr_err, rd_err}, 0);
        chk(empty == 1, "R9 empty after second reset", empty, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule